// File: doc/BRIEF.md
# Programmable Baud Clock Divider with Delayed Start

This block divides a counting tick down to a square-wave baud clock. It holds a 16-bit reload value, a source bit and a run bit. The source bit picks where counting ticks come from. With the bit at 1, every cycle of the system clock is a tick. With the bit at 0, a tick is a cycle in which the external tick input is high. That input stands for the external clock pin or crystal, already brought into the system clock domain as a clock enable. While the block runs, a down-counter steps once per tick. When it reaches zero it reloads, flips the baud output and raises a one-cycle zero-count pulse.

Starting and stopping are not symmetric. After the run bit is set, the first two ticks only arm the generator and the counter loads on the second of them. This gives the start command time to settle against the counting clock. Clearing the run bit stops counting in the same cycle as the write. While stopped, the baud output keeps its last level, and a later start continues from that level.

Top module: `baud_gen`

## Requirements
- R1: After reset, baud_out is 0, zero_pulse is 0, the generator is stopped, and the source bit is 0 (external ticks).
- R2: With the source bit at 1, every clock cycle is a tick. With it at 0, only cycles with ext_tick high are ticks, so with ext_tick low no output ever changes.
- R3: While the run bit is 0, the counter does not count and neither output changes.
- R4: A write with cfg_en=1 while stopped starts the generator. The first and second following ticks do not count, and the counter loads the reload value N on the second of them. The first toggle comes on tick N+3.
- R5: A write with cfg_en=0 takes effect in its own cycle. A tick on the write's clock edge neither toggles baud_out nor pulses zero_pulse.
- R6: While running, the counter steps down once per tick and reloads on the tick that finds it at zero. baud_out therefore toggles every N+1 ticks.
- R7: zero_pulse is high for exactly the one cycle after each reload, and it is high in exactly the cycles in which baud_out has just changed.
- R8: A reload value written while stopped is the one loaded at the next start.
- R9: A reload value written while running does not disturb the count in progress. It is used from the next reload on.
- R10: While stopped, baud_out holds its last level, and the first toggle after a restart inverts that held level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (the system-clock tick source) |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_tick | input | 1 | External tick, a one-cycle clock enable in the clk domain |
| cfg_wr | input | 1 | Write strobe for the run and source bits |
| cfg_en | input | 1 | Run bit value written with cfg_wr |
| cfg_src | input | 1 | Source bit value written with cfg_wr (1 = system clock) |
| tc_wr | input | 1 | Write strobe for the reload value |
| tc_data | input | 16 | Reload value written with tc_wr |
| baud_out | output | 1 | Square-wave baud output |
| zero_pulse | output | 1 | One-cycle pulse at each reload |

## Verification
The assertions check four things on every cycle. A toggle of baud_out always comes with a zero-count pulse, and a pulse always comes with a toggle. A pulse never appears without a tick in the cycle before it. A stop write allows no toggle on the next edge. A start from the stopped state gives no pulse during the arming window. Other behaviour depends on exact tick counts and on when a write falls against the count, and only the bench scenarios show it. These are the N+3 first toggle, the N+1 period, the use of a reload value written mid-count, the held level across a restart and the external tick stride.

// File: rtl/baud_pkg.sv
// Shared types for the baud divider.
// Assumes: nothing beyond a single clock domain.
package baud_pkg;
    // Generator run state
    typedef enum logic [1:0] {
        GEN_OFF = 2'd0,   // stopped, output held
        GEN_ARM = 2'd1,   // start written, swallowing arming ticks
        GEN_RUN = 2'd2    // counting
    } gen_state_e;
endpackage

// File: rtl/baud_tick_sel.sv
// Selects the counting tick: every clock cycle, or the external enable.
// Assumes ext_tick is already synchronous to clk and is one cycle wide.
module baud_tick_sel #(
    parameter bit REGISTER_EXT = 1'b0   // 1: retime the external enable by a cycle
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sel_pclk,
    input  logic ext_tick,
    output logic tick
);
    logic ext_q;

    generate
        if (REGISTER_EXT) begin : g_ext_reg
            // Retime the external enable for timing closure
            always_ff @(posedge clk) begin
                if (!rst_n) ext_q <= 1'b0;
                else        ext_q <= ext_tick;
            end
        end else begin : g_ext_direct
            // Pass the external enable straight through
            always_comb ext_q = ext_tick;
        end
    endgenerate

    // Pick the active source
    always_comb tick = sel_pclk ? 1'b1 : ext_q;
endmodule

// File: rtl/baud_ctrl.sv
// Holds the run, source and reload registers and sequences start/stop.
// A start swallows ARM_TICKS ticks and loads the counter on the last one;
// a stop write cuts counting in the write cycle itself.
// Assumes ARM_TICKS >= 2.
module baud_ctrl
    import baud_pkg::*;
#(
    parameter int TC_W      = 16,
    parameter int ARM_TICKS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic            cfg_en,
    input  logic            cfg_src,
    input  logic            tc_wr,
    input  logic [TC_W-1:0] tc_data,
    input  logic            tick,
    output logic            src_q,
    output logic [TC_W-1:0] tc_q,
    output logic            load,
    output logic            run_tick,
    output logic            gen_off
);
    localparam int AW = (ARM_TICKS > 2) ? $clog2(ARM_TICKS) : 1;
    localparam logic [AW-1:0] ARM_LAST = AW'(ARM_TICKS - 1);

    gen_state_e    state;
    logic [AW-1:0] arm_cnt;
    logic          stop_now;

    // Stop request visible in the write cycle
    always_comb stop_now = cfg_wr && !cfg_en;

    // Counter load on the final arming tick
    always_comb load = (state == GEN_ARM) && tick && (arm_cnt == ARM_LAST) && !stop_now;

    // Counting tick only while running and not being stopped
    always_comb run_tick = (state == GEN_RUN) && tick && !stop_now;

    // Stopped flag for observers
    always_comb gen_off = (state == GEN_OFF);

    // Source bit and reload value registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= 1'b0;
            tc_q  <= '0;
        end else begin
            if (cfg_wr) src_q <= cfg_src;
            if (tc_wr)  tc_q  <= tc_data;
        end
    end

    // Start/stop sequencer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= GEN_OFF;
            arm_cnt <= '0;
        end else if (stop_now) begin
            state   <= GEN_OFF;
            arm_cnt <= '0;
        end else begin
            case (state)
                GEN_OFF: begin
                    if (cfg_wr && cfg_en) begin
                        state   <= GEN_ARM;
                        arm_cnt <= '0;
                    end
                end
                GEN_ARM: begin
                    if (tick) begin
                        if (arm_cnt == ARM_LAST) state <= GEN_RUN;
                        else                     arm_cnt <= arm_cnt + 1'b1;
                    end
                end
                GEN_RUN: state <= GEN_RUN;
                default: state <= GEN_OFF;
            endcase
        end
    end
endmodule

// File: rtl/baud_count.sv
// Down-counter with reload-on-zero, toggling output and zero-count pulse.
// Assumes load and run_tick are never high together.
module baud_count #(
    parameter int TC_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            run_tick,
    input  logic [TC_W-1:0] tc_q,
    output logic            baud_out,
    output logic            zero_pulse
);
    logic [TC_W-1:0] cnt;
    logic            at_zero;

    // Terminal count detect
    always_comb at_zero = (cnt == '0);

    // Count, reload, toggle and pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            baud_out   <= 1'b0;
            zero_pulse <= 1'b0;
        end else begin
            zero_pulse <= 1'b0;
            if (load) begin
                cnt <= tc_q;
            end else if (run_tick) begin
                if (at_zero) begin
                    cnt        <= tc_q;
                    baud_out   <= ~baud_out;
                    zero_pulse <= 1'b1;
                end else begin
                    cnt <= cnt - 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/baud_gen.sv
// Top of the baud divider: tick source select, control and counter.
// Assumes all inputs are synchronous to clk.
module baud_gen #(
    parameter int TC_W      = 16,
    parameter int ARM_TICKS = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ext_tick,
    input  logic            cfg_wr,
    input  logic            cfg_en,
    input  logic            cfg_src,
    input  logic            tc_wr,
    input  logic [TC_W-1:0] tc_data,
    output logic            baud_out,
    output logic            zero_pulse
);
    logic            src_q;
    logic [TC_W-1:0] tc_q;
    logic            tick;
    logic            load;
    logic            run_tick;
    logic            gen_off;

    baud_tick_sel #(.REGISTER_EXT(1'b0)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel_pclk (src_q),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    baud_ctrl #(.TC_W(TC_W), .ARM_TICKS(ARM_TICKS)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_en   (cfg_en),
        .cfg_src  (cfg_src),
        .tc_wr    (tc_wr),
        .tc_data  (tc_data),
        .tick     (tick),
        .src_q    (src_q),
        .tc_q     (tc_q),
        .load     (load),
        .run_tick (run_tick),
        .gen_off  (gen_off)
    );

    baud_count #(.TC_W(TC_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .run_tick   (run_tick),
        .tc_q       (tc_q),
        .baud_out   (baud_out),
        .zero_pulse (zero_pulse)
    );
endmodule

// File: rtl/baud_gen_chk.sv
// Assertion checker for baud_gen, attached by bind.
// Assumes a synchronous active-low reset.
module baud_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic ext_tick,
    input logic cfg_wr,
    input logic cfg_en,
    input logic src_q,
    input logic gen_off,
    input logic baud_out,
    input logic zero_pulse
);
    // R7: a pulse always comes with a fresh toggle
    a_r7_pulse_has_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        zero_pulse |-> (baud_out != $past(baud_out)));

    // R7: a toggle always comes with a pulse
    a_r7_toggle_has_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_out != $past(baud_out)) |-> zero_pulse);

    // R2: a reload needs a tick from the selected source in the cycle before
    a_r2_pulse_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
        zero_pulse |-> $past(src_q || ext_tick));

    // R5: a stop write allows no toggle on the following edge
    a_r5_stop_immediate: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_en) |=> (!zero_pulse && $stable(baud_out)));

    // R4: a start from stopped is silent through the arming window
    a_r4_arm_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_en && gen_off) |=> !zero_pulse ##1 !zero_pulse ##1 !zero_pulse);
endmodule

bind baud_gen baud_gen_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_tick   (ext_tick),
    .cfg_wr     (cfg_wr),
    .cfg_en     (cfg_en),
    .src_q      (src_q),
    .gen_off    (gen_off),
    .baud_out   (baud_out),
    .zero_pulse (zero_pulse)
);

// File: tb/baud_gen_tb.sv
// Scoreboard bench: driver tasks queue expected toggle cycles, monitor compares.
module baud_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_tick = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cfg_en = 1'b0;
    logic        cfg_src = 1'b0;
    logic        tc_wr = 1'b0;
    logic [15:0] tc_data = '0;
    logic        baud_out;
    logic        zero_pulse;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit ext_mode = 1'b0;
    bit done = 1'b0;
    logic prev_baud = 1'b0;
    int exp_q[$];

    baud_gen u_dut (
        .clk(clk), .rst_n(rst_n), .ext_tick(ext_tick),
        .cfg_wr(cfg_wr), .cfg_en(cfg_en), .cfg_src(cfg_src),
        .tc_wr(tc_wr), .tc_data(tc_data),
        .baud_out(baud_out), .zero_pulse(zero_pulse)
    );

    always #2 clk = ~clk;   // 250 MHz

    // Edge counter: at a negedge, cyc is the index of the last posedge
    always @(posedge clk) cyc <= cyc + 1;

    // External tick on every edge whose index is a multiple of 3
    always @(negedge clk) ext_tick <= ext_mode && (((cyc + 1) % 3) == 0);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pops expected toggle cycles as toggles appear
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_baud <= baud_out;
        end else begin
            if (baud_out !== prev_baud) begin
                if (exp_q.size() == 0) begin
                    check("R3/R5 unexpected toggle at cycle", cyc, -1);
                end else begin
                    check("R6 toggle cycle", cyc, exp_q.pop_front());
                end
                check("R7 pulse with toggle", int'(zero_pulse), 1);
            end else if (zero_pulse) begin
                check("R7 pulse without toggle", 0, 1);
            end
            prev_baud <= baud_out;
        end
    end

    // Driver: one write, returns the index of the write edge
    task automatic cfg_write(input bit en, input bit src, output int w);
        cfg_wr = 1'b1; cfg_en = en; cfg_src = src;
        @(negedge clk);
        w = cyc;
        cfg_wr = 1'b0;
    endtask

    task automatic tc_write(input int v, output int w);
        tc_wr = 1'b1; tc_data = 16'(v);
        @(negedge clk);
        w = cyc;
        tc_wr = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic expect_toggle(input int c);
        exp_q.push_back(c);
    endtask

    task automatic drain_check(input string req);
        check(req, exp_q.size(), 0);
        exp_q.delete();
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w, w2, w3, t, t1, held;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 baud_out after reset", int'(baud_out), 0);
        check("R1 zero_pulse after reset", int'(zero_pulse), 0);

        // R1/R2: source defaults to external, no ticks -> never toggles
        tc_write(1, w);
        cfg_write(1'b1, 1'b0, w);
        repeat (30) @(negedge clk);
        check("R2 no toggle without ext ticks", int'(baud_out), 0);
        cfg_write(1'b0, 1'b0, w);

        // R8/R4/R6: reload 3 written while stopped, system-clock source
        tc_write(3, w);
        cfg_write(1'b1, 1'b1, w);
        expect_toggle(w + 6);    // R4: first toggle on tick N+3
        expect_toggle(w + 10);   // R6: period N+1
        expect_toggle(w + 14);
        wait_until(w + 15);
        drain_check("R4 R6 R8 toggles outstanding");

        // R5: stop on the edge that would toggle
        wait_until(w + 17);
        cfg_write(1'b0, 1'b1, w2);
        check("R5 stop edge index", w2, w + 18);
        repeat (20) @(negedge clk);
        drain_check("R5 queue after stop");
        held = int'(baud_out);
        check("R10 held level while stopped", held, 1);

        // R9: reload change while running, R10 restart from held level
        tc_write(2, w);
        cfg_write(1'b1, 1'b1, w2);
        expect_toggle(w2 + 5);
        expect_toggle(w2 + 8);
        wait_until(w2 + 5);
        check("R10 first restart toggle inverts held level", int'(baud_out), 0);
        wait_until(w2 + 8);
        t = w2 + 8;
        tc_write(5, w);
        check("R9 write edge", w, t + 1);
        expect_toggle(t + 3);    // count in progress finishes with old value
        expect_toggle(t + 9);    // new value from the reload on
        wait_until(t + 10);
        cfg_write(1'b0, 1'b1, w);
        repeat (10) @(negedge clk);
        drain_check("R9 toggles outstanding");

        // R2/R3: external ticks every third edge, reload 1
        tc_write(1, w);
        ext_mode = 1'b1;
        @(negedge clk);
        cfg_write(1'b1, 1'b0, w3);
        t1 = (w3 / 3 + 1) * 3;
        expect_toggle(t1 + 9);   // tick 4
        expect_toggle(t1 + 15);  // tick 6
        expect_toggle(t1 + 21);  // tick 8
        wait_until(t1 + 22);
        cfg_write(1'b0, 1'b0, w);
        held = int'(baud_out);
        repeat (30) @(negedge clk);
        check("R3 output frozen while stopped", int'(baud_out), held);
        drain_check("R2 external toggles outstanding");
        ext_mode = 1'b0;

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule